// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block handles RTS/CTS handshaking for a small UART. It sits between the receive FIFO, the transmit engine and the two modem pins. It holds an 8-bit control register. It drives the RTS pin from the amount of free space left in the receive FIFO, or from a modem-control bit that software writes. It also tells the transmitter when it may begin a new character. The serial shifters, the baud generator and the FIFO storage live elsewhere.

The receive path reports its FIFO occupancy on `rx_level`. The block subtracts that count from the FIFO depth to get the number of free entries. It compares this against a threshold picked by a 2-bit field. That field uses a non-monotonic encoding.

On the transmit side, the raw CTS pin passes through a synchronizer chain. Its polarity is then adjusted. When automatic CTS gating is on, the result gates a registered permit. The transmitter's request to start a character is granted only while that permit is high. A character that is already being shifted is not affected, because only the start of a character is gated.

Top module: `uart_flow_ctl`

## Requirements
- R1: While `rst` is high on a clock edge, the control register loads 0x03. Until the first write after reset, `rx_enable` and `tx_enable` read 1. During reset, `rts_pin` and `tx_permit` are 0.
- R2: When `ctrl_we` is high on an edge, `ctrl_wdata` is stored. Bit 0 is receiver enable. Bit 1 is transmitter enable. Bit 2 is automatic RTS. Bit 3 is automatic CTS. Bits 5:4 are the RTS threshold select. Bit 6 inverts RTS. Bit 7 inverts CTS. Bit 0 appears on `rx_enable` and bit 1 on `tx_enable` from the next edge.
- R3: With bit 2 set, the free entry count is computed as depth (8) minus `rx_level`. RTS is active while this count is greater than the threshold. Threshold select 00 means 3 entries, 01 means 2, 10 means 1 and 11 means 4. `rts_pin` updates one edge after `rx_level` or the control register changes.
- R4: With bit 2 set, an active RTS drives `rts_pin` high when bit 6 is 0 and low when bit 6 is 1.
- R5: With bit 2 clear, `rts_pin` follows `mcr_rts` one edge later, with no inversion.
- R6: `cts_pin` passes through two synchronizing flip-flops and then the permit register. A change on the pin reaches `tx_permit` on the third edge after it.
- R7: CTS counts as clear when the synchronized pin is 1 with bit 7 = 0, or 0 with bit 7 = 1. With bit 3 set and CTS not clear, `tx_permit` is 0. With bit 3 clear, CTS has no effect on `tx_permit`.
- R8: With bit 1 clear, `tx_permit` is 0 whatever CTS shows.
- R9: `tx_go` equals `tx_start_req` AND `tx_permit`, so a new character starts only while it is permitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| mcr_rts | input | 1 | Software RTS level used when automatic RTS is off |
| rx_level | input | 4 | Receive FIFO occupancy, 0 to 8 |
| cts_pin | input | 1 | Raw asynchronous CTS pin |
| tx_start_req | input | 1 | Transmitter asks to start the next character |
| rts_pin | output | 1 | RTS pin drive |
| tx_permit | output | 1 | New characters may start |
| tx_go | output | 1 | Start request granted this cycle |
| rx_enable | output | 1 | Receiver enable qualifier |
| tx_enable | output | 1 | Transmitter enable qualifier |

## Verification
The assertions assume that `rx_level` never exceeds the FIFO depth. They also assume that inputs change only between clock edges, so that one-cycle `$past` relations hold. The bench drives every input on the falling edge and sweeps `rx_level` only over 0 to 8. It waits out the synchronizer and register latency after each change before it samples. The sweep covers every threshold code with both RTS polarities, and every combination of CTS pin, CTS inversion, CTS gating and transmitter enable.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

  typedef struct packed {
    logic       cts_inv;
    logic       rts_inv;
    logic [1:0] rts_sel;
    logic       cts_auto;
    logic       rts_auto;
    logic       tx_en;
    logic       rx_en;
  } flow_ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h03;

  // free-entry threshold for each select code (non-monotonic)
  function automatic int unsigned rts_room(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3;
      2'b01:   return 2;
      2'b10:   return 1;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/flow_cts_sync.sv
module flow_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic              past_ok;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R6: the last stage is the first stage delayed through the chain
  assert_sync_chain_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    chain_q[STAGES-1] == $past(chain_q[STAGES-2]));

endmodule

// File: rtl/flow_rts_gen.sv
module flow_rts_gen #(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rts_auto,
  input  logic             rts_inv,
  input  logic [1:0]       rts_sel,
  input  logic             mcr_rts,
  input  logic [LVL_W-1:0] rx_level,
  output logic             rts_o
);
  import uart_flow_pkg::*;

  int unsigned free_cnt;
  logic        room_ok;
  logic        rts_q;
  logic        past_ok;

  always_comb begin
    if (int'(rx_level) >= DEPTH) free_cnt = 0;
    else                         free_cnt = DEPTH - int'(rx_level);
    room_ok = free_cnt > rts_room(rts_sel);
  end

  always_ff @(posedge clk) begin
    if (rst)           rts_q <= 1'b0;
    else if (rts_auto) rts_q <= room_ok ^ rts_inv;
    else               rts_q <= mcr_rts;
  end

  assign rts_o = rts_q;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_rts_full_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(rts_auto && !rts_inv && int'(rx_level) == DEPTH) |-> !rts_o);

  assert_rts_empty_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(rts_auto && !rts_inv && rx_level == '0) |-> rts_o);

  assert_rts_inverted_R4: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(rts_auto && rts_inv && rx_level == '0) |-> !rts_o);

  assert_rts_manual_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(!rts_auto) |-> rts_o == $past(mcr_rts));

endmodule

// File: rtl/flow_tx_gate.sv
module flow_tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic cts_auto,
  input  logic cts_inv,
  input  logic cts_sync,
  output logic permit_o
);

  logic cts_clear;
  logic permit_q;
  logic past_ok;

  assign cts_clear = cts_sync ^ cts_inv;

  always_ff @(posedge clk) begin
    if (rst) permit_q <= 1'b0;
    else     permit_q <= tx_en && (!cts_auto || cts_clear);
  end

  assign permit_o = permit_q;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_cts_hold_R7: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(cts_auto && (cts_sync == cts_inv)) |-> !permit_o);

  assert_cts_ignored_R7: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(tx_en && !cts_auto) |-> permit_o);

  assert_tx_off_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(!tx_en) |-> !permit_o);

endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ctrl_we,
  input  logic [7:0]                      ctrl_wdata,
  input  logic                            mcr_rts,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level,
  input  logic                            cts_pin,
  input  logic                            tx_start_req,
  output logic                            rts_pin,
  output logic                            tx_permit,
  output logic                            tx_go,
  output logic                            rx_enable,
  output logic                            tx_enable
);
  import uart_flow_pkg::*;

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  flow_ctrl_t ctrl_q;
  logic       cts_sync;
  logic       past_ok;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= flow_ctrl_t'(CTRL_RESET);
    else if (ctrl_we) ctrl_q <= flow_ctrl_t'(ctrl_wdata);
  end

  assign rx_enable = ctrl_q.rx_en;
  assign tx_enable = ctrl_q.tx_en;

  flow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (cts_pin),
    .sync_o (cts_sync)
  );

  flow_rts_gen #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_rts (
    .clk      (clk),
    .rst      (rst),
    .rts_auto (ctrl_q.rts_auto),
    .rts_inv  (ctrl_q.rts_inv),
    .rts_sel  (ctrl_q.rts_sel),
    .mcr_rts  (mcr_rts),
    .rx_level (rx_level),
    .rts_o    (rts_pin)
  );

  flow_tx_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (ctrl_q.tx_en),
    .cts_auto (ctrl_q.cts_auto),
    .cts_inv  (ctrl_q.cts_inv),
    .cts_sync (cts_sync),
    .permit_o (tx_permit)
  );

  assign tx_go = tx_start_req & tx_permit;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_ctrl_reset_R1: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(rst) |-> ctrl_q == flow_ctrl_t'(CTRL_RESET));

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(ctrl_we && !rst) |-> ctrl_q == flow_ctrl_t'($past(ctrl_wdata)));

  assert_permit_needs_enable_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    tx_permit |-> $past(ctrl_q.tx_en));

endmodule

// File: tb/uart_flow_ctl_tb.sv
`timescale 1ns/1ps
module uart_flow_ctl_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       ctrl_we;
  logic [7:0] ctrl_wdata;
  logic       mcr_rts;
  logic [3:0] rx_level;
  logic       cts_pin;
  logic       tx_start_req;
  logic       rts_pin, tx_permit, tx_go, rx_enable, tx_enable;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  uart_flow_ctl u_dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .mcr_rts(mcr_rts), .rx_level(rx_level), .cts_pin(cts_pin),
    .tx_start_req(tx_start_req), .rts_pin(rts_pin), .tx_permit(tx_permit),
    .tx_go(tx_go), .rx_enable(rx_enable), .tx_enable(tx_enable)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic int room(input int sel);
    case (sel)
      0: return 3;
      1: return 2;
      2: return 1;
      default: return 4;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ctrl_we = 1'b0; ctrl_wdata = 8'h00; mcr_rts = 1'b0;
    rx_level = 4'd0; cts_pin = 1'b0; tx_start_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", rx_enable, 1'b1);
    chk("R1", tx_enable, 1'b1);
    chk("R1", rts_pin, 1'b0);
    chk("R1", tx_permit, 1'b0);
    rst = 1'b0;
    mcr_rts = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5", rts_pin, 1'b1);
    chk("R7", tx_permit, 1'b1); // auto CTS off after reset: pin ignored

    // R2 enable bits
    wr_ctrl(8'h00);
    chk("R2", rx_enable, 1'b0);
    chk("R2", tx_enable, 1'b0);
    wr_ctrl(8'h01);
    chk("R2", rx_enable, 1'b1);
    chk("R2", tx_enable, 1'b0);
    chk("R8", tx_permit, 1'b0);

    // R5 manual RTS both levels, bit 6 has no effect
    for (int m = 0; m < 2; m++) begin
      wr_ctrl(m ? 8'h43 : 8'h03);
      for (int b = 0; b < 2; b++) begin
        @(negedge clk); mcr_rts = b[0];
        @(negedge clk);
        chk("R5", rts_pin, b[0]);
      end
    end

    // R3/R4 sweep: threshold code x inversion x level
    for (int sel = 0; sel < 4; sel++) begin
      for (int inv = 0; inv < 2; inv++) begin
        wr_ctrl({1'b0, inv[0], sel[1:0], 1'b0, 1'b1, 1'b1, 1'b1});
        for (int lv = 0; lv <= 8; lv++) begin
          @(negedge clk); rx_level = lv[3:0];
          @(negedge clk);
          chk(inv ? "R4" : "R3", rts_pin, ((8 - lv) > room(sel)) ^ inv[0]);
        end
      end
    end
    rx_level = 4'd0;

    // R7/R8 sweep: auto CTS x inversion x pin x tx enable
    for (int ac = 0; ac < 2; ac++)
      for (int ci = 0; ci < 2; ci++)
        for (int te = 0; te < 2; te++)
          for (int p = 0; p < 2; p++) begin
            wr_ctrl({ci[0], 1'b0, 2'b00, ac[0], 1'b0, te[0], 1'b1});
            @(negedge clk); cts_pin = p[0];
            repeat (4) @(negedge clk);
            chk(te ? "R7" : "R8", tx_permit,
                te[0] && (!ac[0] || (p[0] ^ ci[0])));
          end

    // R6 latency through synchronizer and permit register
    wr_ctrl(8'h0B);
    @(negedge clk); cts_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6", tx_permit, 1'b1);
    cts_pin = 1'b0;
    @(negedge clk); chk("R6", tx_permit, 1'b1);
    @(negedge clk); chk("R6", tx_permit, 1'b1);
    @(negedge clk); chk("R6", tx_permit, 1'b0);

    // R9 start grant
    tx_start_req = 1'b1;
    @(negedge clk); chk("R9", tx_go, 1'b0);
    cts_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", tx_go, 1'b1);
    tx_start_req = 1'b0;
    @(negedge clk); chk("R9", tx_go, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule